// File: doc/BRIEF.md
# Fractional Clock Prescaler for a 32 kHz Time Base

This block turns a fast input clock into a tick that fires exactly 32,768 times per second. Two configuration words set the rate. The whole part is the integer number of input clocks per tick, minus one. The remainder is the count of input clocks left over each second once every tick has had its integer share. A down counter produces the basic period. A fraction counter advances once per tick and walks through all of its 32,768 states in one second. For each tick, a small decoder decides whether that period gets one extra input clock.

The decoder gives each remainder bit its own disjoint set of fraction-counter values. Bit k of the remainder owns 2^k values, so the number of stretched periods in a second equals the remainder. The stretched periods are also spread evenly through the second, not grouped together. The tick is a plain control pulse with no handshake, because no data flows through the block. Both configuration words are taken at each reload, and also while reset is held.

Top module: `frac_prescaler`

## Requirements
- R1: While `rst_n` is low, `tick` is low, the fraction counter is cleared and the down counter is loaded with `int_reload` (synchronous reset). The first tick after release appears `int_reload` rising edges after the release.
- R2: A period that is not stretched lasts `int_reload`+1 input clocks, measured from one tick to the next. `int_reload` is sampled in the tick cycle, at the reload.
- R3: A stretched period lasts `int_reload`+2 input clocks. The decision is made when the down counter reaches zero. A stretched period holds zero for one extra cycle, with `tick` low, and the tick comes in the next cycle.
- R4: The fraction counter advances by one on every tick and wraps from 32767 to 0, so one full sweep covers 32,768 ticks.
- R5: Let p be the position of the lowest set bit of the fraction counter. A period is stretched when `frac_val` bit (14−p) is 1. A counter value of 0 never stretches a period, so the first period after reset is never stretched.
- R6: Over the 32,768 periods of one sweep, the total is (`int_reload`+1)×32768 + `frac_val` input clocks, and exactly `frac_val` of those periods are stretched.
- R7: With `frac_val` equal to zero, every period lasts `int_reload`+1 clocks.
- R8: With `frac_val` at or below 16,384, no two stretched periods are adjacent.
- R9: When `int_reload` is nonzero, `tick` is high for exactly one input clock per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_reload | input | 13 | Integer reload value: clocks per tick minus one |
| frac_val | input | 15 | Number of stretched periods per second |
| tick | output | 1 | One-clock pulse at the end of each period |

## Verification
Each test fixes a configuration and measures every tick-to-tick interval against a per-period model of the fraction decoder.

- **Single high remainder bit (16,384), reload of 1:** stretches exactly the odd counter values. This shows whether the decoder uses the lowest set bit or some other bit, and whether the long periods alternate.
- **Reload of 0 with a mixed remainder:** covers the smallest period. It confirms the full-sweep total and that long periods stay separated.
- **All-ones remainder:** stretches every counter value except zero.
- **Zero remainder:** shows that no period is stretched.
- **Realistic reload of 304:** tells a correct reload value apart from an off-by-one reload.

// File: rtl/frac_prescaler_pkg.sv
package frac_prescaler_pkg;
  localparam int unsigned INT_W_DEF  = 13;
  localparam int unsigned FRAC_W_DEF = 15;
endpackage

// File: rtl/prescaler_down_counter.sv
module prescaler_down_counter #(
  parameter int unsigned INT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INT_W-1:0] reload_val,
  input  logic             extend_req,
  output logic [INT_W-1:0] cnt_o,
  output logic             tick_o
);
  logic [INT_W-1:0] cnt_q;
  logic             held_q;
  logic             at_zero;
  logic             stretch;
  logic             fire;

  assign at_zero = (cnt_q == '0);
  assign stretch = at_zero && extend_req && !held_q;
  assign fire    = at_zero && !stretch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= reload_val;
      held_q <= 1'b0;
    end else if (fire) begin
      cnt_q  <= reload_val;
      held_q <= 1'b0;
    end else if (stretch) begin
      held_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign tick_o = fire && rst_n;
endmodule

// File: rtl/prescaler_frac_counter.sv
module prescaler_frac_counter #(
  parameter int unsigned FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  output logic [FRAC_W-1:0] count_o
);
  logic [FRAC_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       count_q <= '0;
    else if (advance) count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;
endmodule

// File: rtl/prescaler_extend_logic.sv
module prescaler_extend_logic #(
  parameter int unsigned FRAC_W = 15
) (
  input  logic [FRAC_W-1:0] frac_count,
  input  logic [FRAC_W-1:0] frac_val,
  output logic              extend_req
);
  // hit[k]: the lowest set bit of frac_count sits at position FRAC_W-1-k
  logic [FRAC_W-1:0] hit;

  for (genvar k = 0; k < FRAC_W; k++) begin : g_sel
    localparam int unsigned P = FRAC_W - 1 - k;
    if (P == 0) begin : g_lsb
      assign hit[k] = frac_count[0];
    end else begin : g_upper
      assign hit[k] = frac_count[P] && (frac_count[P-1:0] == '0);
    end
  end

  assign extend_req = |(hit & frac_val);
endmodule

// File: rtl/frac_prescaler.sv
module frac_prescaler #(
  parameter int unsigned INT_W  = frac_prescaler_pkg::INT_W_DEF,
  parameter int unsigned FRAC_W = frac_prescaler_pkg::FRAC_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  int_reload,
  input  logic [FRAC_W-1:0] frac_val,
  output logic              tick
);
  logic [INT_W-1:0]  down_cnt;
  logic [FRAC_W-1:0] frac_cnt;
  logic              extend_req;
  logic              tick_int;

  prescaler_down_counter #(.INT_W(INT_W)) u_down (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload_val (int_reload),
    .extend_req (extend_req),
    .cnt_o      (down_cnt),
    .tick_o     (tick_int)
  );

  prescaler_frac_counter #(.FRAC_W(FRAC_W)) u_frac (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (tick_int),
    .count_o (frac_cnt)
  );

  prescaler_extend_logic #(.FRAC_W(FRAC_W)) u_ext (
    .frac_count (frac_cnt),
    .frac_val   (frac_val),
    .extend_req (extend_req)
  );

  assign tick = tick_int;
endmodule

// File: rtl/frac_prescaler_chk.sv
module frac_prescaler_chk #(
  parameter int unsigned INT_W  = 13,
  parameter int unsigned FRAC_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [INT_W-1:0]  int_reload,
  input logic              tick,
  input logic [INT_W-1:0]  down_cnt,
  input logic [FRAC_W-1:0] frac_cnt
);
  // R2: reload takes the integer value present in the tick cycle
  assert_reload_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (down_cnt == $past(int_reload)));

  // R2: a nonzero down counter steps down by one
  assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (down_cnt != '0) |=> (down_cnt == INT_W'($past(down_cnt) - 1'b1)));

  // R3: a hold at zero lasts a single cycle, then the tick comes
  assert_single_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((down_cnt == '0) && !tick) |=> tick);

  // R4: fraction counter advances once per tick
  assert_frac_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (frac_cnt == FRAC_W'($past(frac_cnt) + 1'b1)));

  // R4: fraction counter holds between ticks
  assert_frac_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(frac_cnt));

  // R5: counter value zero never stretches
  assert_zero_no_stretch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((frac_cnt == '0) && (down_cnt == '0)) |-> tick);

  // R9: tick lasts one clock when the reload is nonzero
  assert_tick_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (int_reload != '0)) |=> !tick);
endmodule

bind frac_prescaler frac_prescaler_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .int_reload (int_reload),
  .tick       (tick),
  .down_cnt   (down_cnt),
  .frac_cnt   (frac_cnt)
);

// File: tb/frac_prescaler_bench.sv
`timescale 1ns/1ps
module frac_prescaler_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] int_reload = 13'd3;
  logic [14:0] frac_val = 15'd0;
  logic        tick;

  int checks = 0;
  int failures = 0;

  int exp_q[$];
  int cur_int = 0;
  int meas_sum = 0;
  int long_cnt = 0;
  int adj_viol = 0;
  int r9_viol = 0;

  always #2.5 clk = ~clk;

  frac_prescaler u_frac_prescaler (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_reload (int_reload),
    .frac_val   (frac_val),
    .tick       (tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ext_model(input int idx, input int fv);
    int p;
    if (idx == 0) return 0;
    p = 0;
    while (((idx >> p) & 1) == 0) p++;
    return (fv >> (14 - p)) & 1;
  endfunction

  // monitor: measures tick-to-tick spacing and compares with the queue
  initial begin
    int  e;
    int  idx;
    bit  prev_tick;
    bit  prev_long;
    bit  is_long;
    int  expv;
    e = 0; idx = 0; prev_tick = 0; prev_long = 0;
    forever begin
      @(negedge clk);
      #1;
      if (!rst_n) begin
        e = 0; idx = 0; prev_tick = 0; prev_long = 0;
      end else begin
        if (tick) begin
          if (exp_q.size() != 0) begin
            expv = exp_q.pop_front();
            if (idx == 0)
              chk(e == expv, "R1 first tick spacing", e, expv);
            else if (expv > cur_int + 1)
              chk(e == expv, "R3 R5 stretched period", e, expv);
            else
              chk(e == expv, "R2 R5 normal period", e, expv);
            is_long = (idx > 0) && (e > cur_int + 1);
            if (idx > 0) meas_sum += e;
            if (is_long) long_cnt++;
            if (is_long && prev_long) adj_viol++;
            prev_long = is_long;
            idx++;
          end
          e = 0;
        end
        if (tick && prev_tick && cur_int != 0) r9_viol++;
        prev_tick = tick;
        e++;
      end
    end
  end

  task automatic run_cfg(input int iv, input int fv, input int np, input bit adj);
    @(negedge clk);
    rst_n = 1'b0;
    cur_int = iv;
    int_reload = 13'(iv);
    frac_val = 15'(fv);
    exp_q.delete();
    meas_sum = 0; long_cnt = 0; adj_viol = 0; r9_viol = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(tick == 1'b0, "R1 tick low in reset", int'(tick), 0);
    exp_q.push_back(iv);
    for (int i = 1; i < np; i++)
      exp_q.push_back(iv + 1 + ext_model(i % 32768, fv));
    @(negedge clk);
    rst_n = 1'b1;
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    if (np == 32769) begin
      chk(meas_sum == (iv + 1) * 32768 + fv, "R4 R6 sweep total clocks",
          meas_sum, (iv + 1) * 32768 + fv);
      chk(long_cnt == fv, "R6 stretched period count", long_cnt, fv);
    end
    if (fv == 0)
      chk(long_cnt == 0, "R7 no stretched periods", long_cnt, 0);
    if (adj)
      chk(adj_viol == 0, "R8 adjacent stretched periods", adj_viol, 0);
    if (iv != 0)
      chk(r9_viol == 0, "R9 tick wider than one clock", r9_viol, 0);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    run_cfg(304, 0, 20, 1'b0);        // R7 flat rate
    run_cfg(304, 5760, 40, 1'b0);     // realistic reload
    run_cfg(1, 32767, 40, 1'b0);      // R5 all-ones remainder
    run_cfg(1, 16384, 32769, 1'b1);   // R5 R8 odd values only
    run_cfg(0, 12345, 32769, 1'b1);   // R4 R6 R8 smallest period
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule